// File: doc/BRIEF.md
# Wiper Position Counter Register

This block keeps the six-bit tap position of one potentiometer channel and turns it into a 64-wide one-hot tap select. The position can change in four ways. It can take a word from one of four data registers that sit beside it. It can take a word written by the host. It can move one tap up or down in response to a step pulse. It also reloads itself from data register zero once reset is released. The serial front end, the nonvolatile storage and the resistor ladder all sit outside this block. Those outside parts give it ready-decoded load strobes, the four stored words and step pulses.

The position is volatile. Any reset clears it, and the next clock edge refills it from data register zero, whatever was held before. When several sources request a change in the same cycle, one fixed order decides which one wins. Stepping stops at the two ends of the ladder and never wraps around.

Top module: `wiper_pos_reg`

## Requirements
- R1: While rst_n is low, pos_o is 0 and tap_sel_o has only bit 0 set.
- R2: On the first rising clock edge after rst_n goes high, pos_o takes the value of data register zero (bank bits [5:0]). All other request inputs in that cycle are ignored.
- R3: When xfer_en_i is high, pos_o takes data register xfer_sel_i on the next edge. Register k occupies bank bits [6k+5:6k].
- R4: When host_wr_en_i is high and no transfer is requested, pos_o takes host_wr_data_i on the next edge.
- R5: When step_en_i is the only request, pos_o rises by one if step_up_i is 1 and falls by one if step_up_i is 0.
- R6: A step up at 63 leaves pos_o at 63, and a step down at 0 leaves pos_o at 0.
- R7: The priority order is reset reload first, then transfer, then host write, then step.
- R8: tap_sel_o always has exactly one bit set, and that bit is bit pos_o. Position 0 selects the low end of the ladder and 63 selects the high end.
- R9: With no request active, pos_o holds its value.
- R10: A reset asserted during operation clears pos_o. After release, pos_o is reloaded from data register zero rather than keeping its earlier value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| dreg_bank_i | input | 24 | Four stored words; word k is at bits [6k+5:6k] |
| xfer_en_i | input | 1 | Load from a data register |
| xfer_sel_i | input | 2 | Index of the data register to load |
| host_wr_en_i | input | 1 | Load the host write word |
| host_wr_data_i | input | 6 | Host write word |
| step_en_i | input | 1 | Move the position by one tap |
| step_up_i | input | 1 | Step direction: 1 toward high end, 0 toward low end |
| pos_o | output | 6 | Current tap position |
| tap_sel_o | output | 64 | One-hot tap select |

## Verification
The assertions assume that every request input is a clean synchronous level, sampled only at the rising edge. They also assume that the data register bank is stable in the cycle a transfer or reload samples it. The bench changes every input one time unit after a rising edge, so each value is settled well before the next edge. Random cycles draw each request enable on its own, so every mix of concurrent requests appears. Directed runs start the position near 0 and 63 and then step against each end.

// File: rtl/wiper_pkg.sv
package wiper_pkg;
    typedef enum logic [2:0] {
        SRC_NONE,
        SRC_BOOT,
        SRC_XFER,
        SRC_HOST,
        SRC_STEP
    } wiper_src_e;
endpackage

// File: rtl/wiper_step_unit.sv
module wiper_step_unit #(
    parameter int POS_W = 6
) (
    input  logic [POS_W-1:0] pos_i,
    input  logic             up_i,
    output logic [POS_W-1:0] stepped_o
);
    localparam logic [POS_W-1:0] POS_MAX = {POS_W{1'b1}};
    localparam logic [POS_W-1:0] POS_MIN = '0;

    always_comb begin
        stepped_o = pos_i;
        if (up_i) begin
            if (pos_i != POS_MAX) stepped_o = pos_i + 1'b1;
        end else begin
            if (pos_i != POS_MIN) stepped_o = pos_i - 1'b1;
        end
    end
endmodule

// File: rtl/wiper_src_arbiter.sv
module wiper_src_arbiter
    import wiper_pkg::*;
#(
    parameter int POS_W = 6
) (
    input  logic             boot_i,
    input  logic [POS_W-1:0] boot_word_i,
    input  logic             xfer_i,
    input  logic [POS_W-1:0] xfer_word_i,
    input  logic             host_i,
    input  logic [POS_W-1:0] host_word_i,
    input  logic             step_i,
    input  logic [POS_W-1:0] step_word_i,
    output wiper_src_e       src_o,
    output logic [POS_W-1:0] word_o
);
    always_comb begin
        src_o  = SRC_NONE;
        word_o = '0;
        if (boot_i) begin
            src_o  = SRC_BOOT;
            word_o = boot_word_i;
        end else if (xfer_i) begin
            src_o  = SRC_XFER;
            word_o = xfer_word_i;
        end else if (host_i) begin
            src_o  = SRC_HOST;
            word_o = host_word_i;
        end else if (step_i) begin
            src_o  = SRC_STEP;
            word_o = step_word_i;
        end
    end
endmodule

// File: rtl/wiper_tap_decode.sv
module wiper_tap_decode #(
    parameter int POS_W = 6
) (
    input  logic [POS_W-1:0]        pos_i,
    output logic [(1<<POS_W)-1:0]   tap_o
);
    localparam int NUM_TAPS = 1 << POS_W;

    for (genvar t = 0; t < NUM_TAPS; t++) begin : g_tap
        assign tap_o[t] = (pos_i == POS_W'(t));
    end
endmodule

// File: rtl/wiper_pos_reg.sv
module wiper_pos_reg
    import wiper_pkg::*;
#(
    parameter int POS_W    = 6,
    parameter int NUM_DREG = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_DREG*POS_W-1:0]   dreg_bank_i,
    input  logic                        xfer_en_i,
    input  logic [$clog2(NUM_DREG)-1:0] xfer_sel_i,
    input  logic                        host_wr_en_i,
    input  logic [POS_W-1:0]            host_wr_data_i,
    input  logic                        step_en_i,
    input  logic                        step_up_i,
    output logic [POS_W-1:0]            pos_o,
    output logic [(1<<POS_W)-1:0]       tap_sel_o
);
    localparam int NUM_TAPS = 1 << POS_W;
    localparam logic [POS_W-1:0] POS_MAX = {POS_W{1'b1}};

    typedef struct packed {
        logic [POS_W-1:0] pos;
        logic             boot;
    } state_t;

    state_t state_d, state_q;

    logic [POS_W-1:0] xfer_word;
    logic [POS_W-1:0] step_word;
    logic [POS_W-1:0] next_word;
    wiper_src_e       src;

    assign xfer_word = dreg_bank_i[xfer_sel_i*POS_W +: POS_W];

    wiper_step_unit #(.POS_W(POS_W)) u_step (
        .pos_i     (state_q.pos),
        .up_i      (step_up_i),
        .stepped_o (step_word)
    );

    wiper_src_arbiter #(.POS_W(POS_W)) u_arb (
        .boot_i      (state_q.boot),
        .boot_word_i (dreg_bank_i[POS_W-1:0]),
        .xfer_i      (xfer_en_i),
        .xfer_word_i (xfer_word),
        .host_i      (host_wr_en_i),
        .host_word_i (host_wr_data_i),
        .step_i      (step_en_i),
        .step_word_i (step_word),
        .src_o       (src),
        .word_o      (next_word)
    );

    always_comb begin
        state_d      = state_q;
        state_d.boot = 1'b0;
        if (src != SRC_NONE) state_d.pos = next_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.pos  <= '0;
            state_q.boot <= 1'b1;
        end else begin
            state_q <= state_d;
        end
    end

    assign pos_o = state_q.pos;

    wiper_tap_decode #(.POS_W(POS_W)) u_dec (
        .pos_i (state_q.pos),
        .tap_o (tap_sel_o)
    );

    // R2: first edge after release reloads register zero
    a_r2_boot_reload: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.boot |=> pos_o == $past(dreg_bank_i[POS_W-1:0]));

    // R3: transfer wins over host and step
    a_r3_xfer_load: assert property (@(posedge clk) disable iff (!rst_n)
        (!state_q.boot && xfer_en_i) |=> pos_o == $past(xfer_word));

    // R4 / R7: host write over step
    a_r4_host_load: assert property (@(posedge clk) disable iff (!rst_n)
        (!state_q.boot && !xfer_en_i && host_wr_en_i) |=> pos_o == $past(host_wr_data_i));

    // R6: saturation at both ends
    a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (!state_q.boot && !xfer_en_i && !host_wr_en_i && step_en_i && step_up_i
         && pos_o == POS_MAX) |=> pos_o == POS_MAX);
    a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (!state_q.boot && !xfer_en_i && !host_wr_en_i && step_en_i && !step_up_i
         && pos_o == '0) |=> pos_o == '0);

    // R8: exactly one tap, at the position
    a_r8_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(tap_sel_o) == 1 && tap_sel_o[pos_o]);

    // R9: idle holds
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!state_q.boot && !xfer_en_i && !host_wr_en_i && !step_en_i) |=> $stable(pos_o));

    initial begin
        if (NUM_TAPS < 2) $error("POS_W too small");
    end
endmodule

// File: tb/wiper_pos_reg_tb_top.sv
`timescale 1ns/1ps
module wiper_pos_reg_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] dreg_bank_i = '0;
    logic        xfer_en_i = 1'b0;
    logic [1:0]  xfer_sel_i = '0;
    logic        host_wr_en_i = 1'b0;
    logic [5:0]  host_wr_data_i = '0;
    logic        step_en_i = 1'b0;
    logic        step_up_i = 1'b0;
    logic [5:0]  pos_o;
    logic [63:0] tap_sel_o;

    int tests = 0;
    int fails = 0;
    logic [5:0] exp_pos = '0;
    logic       exp_boot = 1'b1;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    wiper_pos_reg dut_i (
        .clk(clk), .rst_n(rst_n), .dreg_bank_i(dreg_bank_i),
        .xfer_en_i(xfer_en_i), .xfer_sel_i(xfer_sel_i),
        .host_wr_en_i(host_wr_en_i), .host_wr_data_i(host_wr_data_i),
        .step_en_i(step_en_i), .step_up_i(step_up_i),
        .pos_o(pos_o), .tap_sel_o(tap_sel_o)
    );

    function automatic logic [5:0] model_next(logic [5:0] p, logic boot);
        if (boot) return dreg_bank_i[5:0];
        if (xfer_en_i) return dreg_bank_i[xfer_sel_i*6 +: 6];
        if (host_wr_en_i) return host_wr_data_i;
        if (step_en_i) begin
            if (step_up_i) return (p == 6'd63) ? p : p + 6'd1;
            return (p == 6'd0) ? p : p - 6'd1;
        end
        return p;
    endfunction

    function automatic string req_tag(logic boot);
        if (boot) return "R2";
        if (xfer_en_i) return (host_wr_en_i || step_en_i) ? "R7" : "R3";
        if (host_wr_en_i) return step_en_i ? "R7" : "R4";
        if (step_en_i) return "R5/R6";
        return "R9";
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_out(string tag);
        check(tag, {58'd0, pos_o}, {58'd0, exp_pos});
        check("R8", tap_sel_o, 64'd1 << exp_pos);
    endtask

    task automatic idle();
        xfer_en_i = 0; host_wr_en_i = 0; step_en_i = 0;
    endtask

    task automatic cycle();
        string tag;
        tag = req_tag(exp_boot);
        exp_pos = model_next(exp_pos, exp_boot);
        exp_boot = 1'b0;
        @(posedge clk); #1;
        check_out(tag);
    endtask

    task automatic do_reset();
        rst_n = 0;
        #3;
        exp_pos = 0; exp_boot = 1;
        check("R1", {58'd0, pos_o}, 64'd0);
        check("R1", tap_sel_o, 64'd1);
        @(posedge clk); #1;
        rst_n = 1;
    endtask

    initial begin
        #400000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        dreg_bank_i = {6'd40, 6'd63, 6'd1, 6'd21};
        idle();
        do_reset();
        // R2: boot reload beats a concurrent transfer and host write
        xfer_en_i = 1; xfer_sel_i = 2'd2; host_wr_en_i = 1; host_wr_data_i = 6'd9;
        cycle();
        idle();
        cycle();               // R9 hold
        // R6: near the high end
        xfer_en_i = 1; xfer_sel_i = 2'd2; cycle(); idle();
        step_en_i = 1; step_up_i = 1;
        for (int i = 0; i < 3; i++) cycle();
        // R6: near the low end
        idle(); xfer_en_i = 1; xfer_sel_i = 2'd1; cycle(); idle();
        step_en_i = 1; step_up_i = 0;
        for (int i = 0; i < 3; i++) cycle();
        idle();
        // R7: host beats step
        host_wr_en_i = 1; host_wr_data_i = 6'd33; step_en_i = 1; step_up_i = 1; cycle();
        idle();
        // R10: reset mid-operation, then reload of a changed register zero
        dreg_bank_i[5:0] = 6'd50;
        do_reset();
        cycle();
        if (pos_o !== 6'd50) begin
            fails++; tests++;
            $display("FAIL R10 actual=%0d expected=50", pos_o);
        end else tests++;
        // random phase
        for (int n = 0; n < 3000; n++) begin
            dreg_bank_i    = 24'($urandom);
            xfer_en_i      = ($urandom % 6) == 0;
            xfer_sel_i     = 2'($urandom);
            host_wr_en_i   = ($urandom % 6) == 0;
            host_wr_data_i = 6'($urandom);
            step_en_i      = ($urandom % 2) == 0;
            step_up_i      = (n / 200) % 2 == 0 ? (($urandom % 8) != 0) : (($urandom % 8) == 0);
            cycle();
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule